// File: doc/BRIEF.md
# Circular Message Buffer Pointer Engine

This block manages one pair of circular regions in a shared word-wide RAM on behalf of a serial-bus remote terminal. One region holds received message data. The other holds a two-word status record for each message: an information word and a time-tag word. Command decoding, legality checks and time-tag generation happen upstream. The upstream logic presents a message-complete event that carries the RAM address of a four-word descriptor, the direction, a combined "bad" flag (error, busy response or illegal command), the data word count, the information word and the time-tag word.

On each accepted event the engine reads the descriptor and writes the status record. For good receive messages it also copies the data words into the data region. For good messages it then writes the advanced pointers back. The control word sets a power-of-two message count per cycle. The engine detects the end of a cycle when the low bits of the incremented record pointer are all ones. At that point it rewinds both pointers to their base values. If the interrupt is enabled, it also pulses the interrupt output. All RAM traffic uses one request/acknowledge port, one transfer at a time.

Top module: `circbuf_ptr_engine`

## Requirements
- R1: After an event is accepted, the first four RAM transfers read the descriptor at N, N+1, N+2 and N+3, in that order. These hold the control word, the data start address, the data current address and the record pointer. `busy` is high from the cycle after acceptance until the last transfer of that event has been acknowledged, and `mem_req` is never high while `busy` is low.
- R2: The mode is active only when control bit 2 is 0 and control bit 1 is 1. Bits 0 and 3 have no effect. When the mode is inactive, the engine performs the four descriptor reads and no write.
- R3: Every message in an active descriptor writes its information word at the record pointer P and its time-tag word at P+1, in that order, including messages flagged bad.
- R4: A message flagged bad makes no data writes and no descriptor write-back. The record pointer therefore stays unchanged, and the next message overwrites the same two-word slot.
- R5: A good receive message with count n writes data word i (taken from `dat_word` while `dat_idx` = i) at current address C+i, for i = 0 to n-1 in rising order. Unless the cycle wraps, the engine then writes C+n back to N+2 before it writes the record pointer to N+3.
- R6: A good transmit message writes no data and writes the current address back unchanged, unless the cycle wraps.
- R7: Control bits 7:4 hold a code k that selects 2^k good messages per cycle for k = 0 to 9. Codes 10 to 15 behave as code 9.
- R8: On a good message, the engine tests whether the low k+1 bits of P+1 are all ones. If they are not, the engine writes back P+2. If they are, it writes back P with those k+1 bits cleared, and it writes the data start address back as the current address.
- R9: When a wrap is written back, `wrap_irq` pulses high for exactly one cycle, while `busy` is low, and only if `wrap_irq_en` was high at acceptance. No other message produces a pulse.
- R10: While `mem_req` is high and `mem_ack` is low, the request, address, write enable and write data stay stable. Each acknowledged cycle completes exactly one transfer.
- R11: `evt_valid` while `busy` is high is ignored. It causes no extra transfer and does not change the event in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Message-complete event, taken when idle |
| evt_desc | input | 16 | RAM address N of the descriptor |
| evt_is_rx | input | 1 | 1 = receive message, 0 = transmit |
| evt_bad | input | 1 | Error, busy response or illegal command |
| evt_wcnt | input | 6 | Number of data words |
| evt_info | input | 16 | Message information word |
| evt_ttag | input | 16 | Time-tag word |
| wrap_irq_en | input | 1 | Enables the wrap interrupt for this event |
| dat_idx | output | 6 | Index of the data word wanted |
| dat_word | input | 16 | Data word at `dat_idx` |
| busy | output | 1 | Event in progress |
| wrap_irq | output | 1 | One-cycle cycle-complete interrupt |
| mem_req | output | 1 | RAM transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_ack | input | 1 | Transfer done; read data valid |
| mem_rdata | input | 16 | RAM read data |

## Verification
The assertions check four things on every cycle. The RAM port holds stable while it waits for an acknowledge, requests happen only while busy, an interrupt pulse never overlaps busy, and busy rises only after an event. They also check that a bad message ends the event right after its time-tag write. The bench's scenarios are needed for the ordered address and data of every transfer, the skipped pointer advance for bad messages, and the rewind exactly at count 1, 4 and 512, including the clamped code. They also cover interrupt gating, inactive-mode descriptors and events presented while busy.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    // control word field positions
    localparam int unsigned CBP_C1_BIT   = 0;
    localparam int unsigned CBP_C2_BIT   = 1;
    localparam int unsigned CBP_PP_BIT   = 2;
    localparam int unsigned CBP_DB_BIT   = 3;
    localparam int unsigned CBP_CODE_LSB = 4;
    localparam int unsigned CBP_CODE_W   = 4;

    typedef enum logic [3:0] {
        S_IDLE     = 4'd0,
        S_RD_CTRL  = 4'd1,
        S_RD_START = 4'd2,
        S_RD_CUR   = 4'd3,
        S_RD_INFO  = 4'd4,
        S_WR_MI    = 4'd5,
        S_WR_TT    = 4'd6,
        S_WR_DAT   = 4'd7,
        S_WB_CUR   = 4'd8,
        S_WB_INFO  = 4'd9
    } cbp_state_e;

endpackage

// File: rtl/cbp_span_mask.sv
// Builds a mask of the low (k+1) address bits for message-count code k.
module cbp_span_mask #(
    parameter int AW       = 16,
    parameter int CODE_W   = 4,
    parameter int CODE_MAX = 9
) (
    input  logic [CODE_W-1:0] code,
    output logic [AW-1:0]     mask
);
    logic [CODE_W-1:0] code_c;

    assign code_c = (code > CODE_W'(CODE_MAX)) ? CODE_W'(CODE_MAX) : code;

    for (genvar g = 0; g < AW; g++) begin : g_bit
        assign mask[g] = (32'(g) <= 32'(code_c));
    end
endmodule

// File: rtl/cbp_info_step.sv
// Next record pointer: detect all-ones low field of P+1, else step by two.
module cbp_info_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] info,
    input  logic [AW-1:0] mask,
    output logic [AW-1:0] info_next,
    output logic          full
);
    logic [AW-1:0] info_inc;

    assign info_inc  = info + AW'(1);
    assign full      = ((info_inc & mask) == mask);
    assign info_next = full ? (info & ~mask) : (info + AW'(2));
endmodule

// File: rtl/circbuf_ptr_engine.sv
module circbuf_ptr_engine
    import cbp_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 16,
    parameter int WCW      = 6,
    parameter int CODE_MAX = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           evt_valid,
    input  logic [AW-1:0]  evt_desc,
    input  logic           evt_is_rx,
    input  logic           evt_bad,
    input  logic [WCW-1:0] evt_wcnt,
    input  logic [DW-1:0]  evt_info,
    input  logic [DW-1:0]  evt_ttag,
    input  logic           wrap_irq_en,
    output logic [WCW-1:0] dat_idx,
    input  logic [DW-1:0]  dat_word,
    output logic           busy,
    output logic           wrap_irq,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata
);
    localparam int CW = CBP_CODE_W;

    typedef struct packed {
        cbp_state_e     st;
        logic [AW-1:0]  desc;
        logic [AW-1:0]  start;
        logic [AW-1:0]  cur;
        logic [AW-1:0]  info;
        logic           rx;
        logic           bad;
        logic           irq_en;
        logic           irq;
        logic           mode_ok;
        logic [CW-1:0]  code;
        logic [WCW-1:0] wcnt;
        logic [WCW-1:0] idx;
        logic [DW-1:0]  miw;
        logic [DW-1:0]  ttw;
    } regs_t;

    regs_t st_q, st_d;

    logic [AW-1:0] span_mask;
    logic [AW-1:0] info_next;
    logic          wrap_full;
    logic [AW-1:0] cur_next;

    cbp_span_mask #(
        .AW       (AW),
        .CODE_W   (CW),
        .CODE_MAX (CODE_MAX)
    ) u_mask (
        .code (st_q.code),
        .mask (span_mask)
    );

    cbp_info_step #(
        .AW (AW)
    ) u_step (
        .info      (st_q.info),
        .mask      (span_mask),
        .info_next (info_next),
        .full      (wrap_full)
    );

    assign cur_next = wrap_full ? st_q.start
                    : (st_q.rx ? st_q.cur + AW'(st_q.wcnt) : st_q.cur);

    // RAM port driven purely from state
    always_comb begin
        mem_req   = (st_q.st != S_IDLE);
        mem_we    = 1'b0;
        mem_addr  = st_q.desc;
        mem_wdata = '0;
        unique case (st_q.st)
            S_RD_START: mem_addr = st_q.desc + AW'(1);
            S_RD_CUR:   mem_addr = st_q.desc + AW'(2);
            S_RD_INFO:  mem_addr = st_q.desc + AW'(3);
            S_WR_MI: begin
                mem_we    = 1'b1;
                mem_addr  = st_q.info;
                mem_wdata = st_q.miw;
            end
            S_WR_TT: begin
                mem_we    = 1'b1;
                mem_addr  = st_q.info + AW'(1);
                mem_wdata = st_q.ttw;
            end
            S_WR_DAT: begin
                mem_we    = 1'b1;
                mem_addr  = st_q.cur + AW'(st_q.idx);
                mem_wdata = dat_word;
            end
            S_WB_CUR: begin
                mem_we    = 1'b1;
                mem_addr  = st_q.desc + AW'(2);
                mem_wdata = cur_next;
            end
            S_WB_INFO: begin
                mem_we    = 1'b1;
                mem_addr  = st_q.desc + AW'(3);
                mem_wdata = info_next;
            end
            default: ;
        endcase
    end

    // next-state computation
    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        unique case (st_q.st)
            S_IDLE: begin
                if (evt_valid) begin
                    st_d.st     = S_RD_CTRL;
                    st_d.desc   = evt_desc;
                    st_d.rx     = evt_is_rx;
                    st_d.bad    = evt_bad;
                    st_d.wcnt   = evt_wcnt;
                    st_d.miw    = evt_info;
                    st_d.ttw    = evt_ttag;
                    st_d.irq_en = wrap_irq_en;
                    st_d.idx    = '0;
                end
            end
            S_RD_CTRL: begin
                if (mem_ack) begin
                    st_d.mode_ok = !mem_rdata[CBP_PP_BIT] && mem_rdata[CBP_C2_BIT];
                    st_d.code    = mem_rdata[CBP_CODE_LSB +: CW];
                    st_d.st      = S_RD_START;
                end
            end
            S_RD_START: begin
                if (mem_ack) begin
                    st_d.start = mem_rdata;
                    st_d.st    = S_RD_CUR;
                end
            end
            S_RD_CUR: begin
                if (mem_ack) begin
                    st_d.cur = mem_rdata;
                    st_d.st  = S_RD_INFO;
                end
            end
            S_RD_INFO: begin
                if (mem_ack) begin
                    st_d.info = mem_rdata;
                    st_d.st   = st_q.mode_ok ? S_WR_MI : S_IDLE;
                end
            end
            S_WR_MI: begin
                if (mem_ack) st_d.st = S_WR_TT;
            end
            S_WR_TT: begin
                if (mem_ack) begin
                    if (st_q.bad)
                        st_d.st = S_IDLE;
                    else if (st_q.rx && (st_q.wcnt != '0))
                        st_d.st = S_WR_DAT;
                    else
                        st_d.st = S_WB_CUR;
                end
            end
            S_WR_DAT: begin
                if (mem_ack) begin
                    st_d.idx = st_q.idx + WCW'(1);
                    if (st_q.idx + WCW'(1) == st_q.wcnt) st_d.st = S_WB_CUR;
                end
            end
            S_WB_CUR: begin
                if (mem_ack) st_d.st = S_WB_INFO;
            end
            S_WB_INFO: begin
                if (mem_ack) begin
                    st_d.st  = S_IDLE;
                    st_d.irq = wrap_full && st_q.irq_en;
                end
            end
            default: st_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = (st_q.st != S_IDLE);
    assign wrap_irq = st_q.irq;
    assign dat_idx  = st_q.idx;

    // R10
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R1
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R9
    irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_irq |-> (!busy && !$past(wrap_irq)));

    // R11
    accept_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(evt_valid));

    // R4
    bad_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.st == S_WR_TT && mem_ack && st_q.bad) |=> !busy);

endmodule

// File: tb/circbuf_ptr_engine_bench.sv
`timescale 1ns/1ps
module circbuf_ptr_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [15:0] evt_desc = '0;
    logic        evt_is_rx = 1'b0;
    logic        evt_bad = 1'b0;
    logic [5:0]  evt_wcnt = '0;
    logic [15:0] evt_info = '0;
    logic [15:0] evt_ttag = '0;
    logic        wrap_irq_en = 1'b0;
    logic [5:0]  dat_idx;
    logic [15:0] dat_word;
    logic        busy, wrap_irq, mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;

    always #2 clk = ~clk;

    int msg_seq = 0;
    assign dat_word = {msg_seq[7:0], 2'b00, dat_idx};

    circbuf_ptr_engine u_circbuf_ptr_engine (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_desc(evt_desc),
        .evt_is_rx(evt_is_rx), .evt_bad(evt_bad), .evt_wcnt(evt_wcnt),
        .evt_info(evt_info), .evt_ttag(evt_ttag), .wrap_irq_en(wrap_irq_en),
        .dat_idx(dat_idx), .dat_word(dat_word), .busy(busy), .wrap_irq(wrap_irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    typedef struct {
        bit          we;
        logic [15:0] a;
        logic [15:0] d;
        string       tag;
    } txn_t;

    txn_t        exp_q[$];
    logic [31:0] pre_q[$];
    logic [15:0] mem[int];

    int mon_ptr = 0, pre_ptr = 0, mon_checks = 0, mon_fails = 0, mon_irq = 0;
    int checks = 0, fails = 0;

    function automatic logic [15:0] rd16(input logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
    endfunction

    // RAM model and transfer-by-transfer comparison, on the falling edge
    always @(negedge clk) begin
        txn_t t;
        while (pre_ptr < pre_q.size()) begin
            mem[int'(pre_q[pre_ptr][31:16])] = pre_q[pre_ptr][15:0];
            pre_ptr++;
        end
        if (!rst_n) mem_ack <= 1'b0;
        else if (mem_ack) mem_ack <= 1'b0;
        else if (mem_req && $urandom_range(3) != 0) begin
            mem_ack <= 1'b1;
            mon_checks++;
            if (mon_ptr >= exp_q.size()) begin
                mon_fails++;
                $display("FAIL R11 unexpected transfer we=%0b addr=%h data=%h expected none",
                         mem_we, mem_addr, mem_wdata);
            end else begin
                t = exp_q[mon_ptr];
                mon_ptr++;
                if (t.we !== mem_we || t.a !== mem_addr || (t.we && t.d !== mem_wdata)) begin
                    mon_fails++;
                    $display("FAIL %s transfer got we=%0b addr=%h data=%h expected we=%0b addr=%h data=%h",
                             t.tag, mem_we, mem_addr, mem_wdata, t.we, t.a, t.d);
                end
            end
            if (mem_we) mem[int'(mem_addr)] = mem_wdata;
            else        mem_rdata <= rd16(mem_addr);
        end
        if (wrap_irq) mon_irq++;
    end

    // reference model state for the descriptor under test
    logic [15:0] m_desc, m_start, m_cur, m_base;
    int          m_k, m_good;
    bit          m_mode;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push(input bit we, input logic [15:0] a, input logic [15:0] d, input string tag);
        txn_t t;
        t.we = we; t.a = a; t.d = d; t.tag = tag;
        exp_q.push_back(t);
    endtask

    task automatic setup(input logic [15:0] n, input logic [15:0] ctrl,
                         input logic [15:0] start, input logic [15:0] base);
        int code;
        pre_q.push_back({n, ctrl});
        pre_q.push_back({n + 16'd1, start});
        pre_q.push_back({n + 16'd2, start});
        pre_q.push_back({n + 16'd3, base});
        m_desc = n; m_start = start; m_cur = start; m_base = base; m_good = 0;
        m_mode = !ctrl[2] && ctrl[1];          // R2
        code   = int'(ctrl[7:4]);
        m_k    = (code > 9) ? 9 : code;        // R7
        tick(); tick();
    endtask

    task automatic send(input bit rx, input bit bad, input int n, input bit ien, input bit poke);
        int          irq0, exp_irq;
        logic [15:0] ip, miw, ttw;
        string       wbtag;
        msg_seq++;
        miw = 16'hA000 ^ msg_seq[15:0];
        ttw = 16'h5000 + 16'(msg_seq * 7);
        exp_irq = 0;
        for (int i = 0; i < 4; i++) push(1'b0, m_desc + 16'(i), 16'h0, "R1");
        if (m_mode) begin
            ip = m_base + 16'(2 * m_good);
            push(1'b1, ip, miw, bad ? "R4" : "R3");
            push(1'b1, ip + 16'd1, ttw, "R3");
            if (!bad) begin
                if (rx)
                    for (int i = 0; i < n; i++)
                        push(1'b1, m_cur + 16'(i), {msg_seq[7:0], 2'b00, 6'(i)}, "R5");
                m_good++;
                if (m_good == (1 << m_k)) begin
                    m_good = 0; m_cur = m_start; wbtag = "R8";
                    if (ien) exp_irq = 1;
                end else begin
                    if (rx) m_cur = m_cur + 16'(n);
                    wbtag = rx ? "R5" : "R6";
                end
                push(1'b1, m_desc + 16'd2, m_cur, wbtag);
                push(1'b1, m_desc + 16'd3, m_base + 16'(2 * m_good), "R8");
            end
        end
        irq0 = mon_irq;
        evt_desc = m_desc; evt_is_rx = rx; evt_bad = bad; evt_wcnt = 6'(n);
        evt_info = miw; evt_ttag = ttw; wrap_irq_en = ien; evt_valid = 1'b1;
        tick();
        evt_valid = 1'b0;
        check(busy === 1'b1, "R1 busy after accept", int'(busy), 1);
        if (poke) begin
            // R11: event offered while busy must be dropped
            evt_valid = 1'b1; evt_desc = 16'hBEEF; evt_info = 16'h1234;
            tick();
            evt_valid = 1'b0;
        end
        while (busy) tick();
        tick(); tick();
        check(mon_ptr == exp_q.size(), "R10 transfer count", mon_ptr, exp_q.size());
        check(mon_irq - irq0 == exp_irq, "R9 wrap interrupt", mon_irq - irq0, exp_irq);
    endtask

    task automatic run_all();
        repeat (3) tick();
        check(busy === 1'b0, "R1 reset busy", int'(busy), 0);
        check(mem_req === 1'b0, "R10 reset req", int'(mem_req), 0);
        check(wrap_irq === 1'b0, "R9 reset irq", int'(wrap_irq), 0);
        rst_n = 1'b1;
        tick(); tick();

        // R7 count 1: every good message wraps
        setup(16'h0100, 16'h0002, 16'h2000, 16'h3000);
        send(1, 0, 2, 1, 0);
        send(1, 0, 3, 1, 0);
        send(1, 1, 2, 1, 0);
        send(0, 0, 0, 1, 0);

        // R2 ignored bits 0 and 3 set; count 4
        setup(16'h0200, 16'h002B, 16'h4000, 16'h5000);
        send(1, 0, 2, 1, 0);
        send(0, 0, 0, 1, 1);
        send(1, 1, 3, 1, 0);   // error mid cycle
        send(1, 0, 1, 1, 0);
        send(1, 1, 1, 1, 0);   // busy response mid cycle
        send(0, 0, 0, 1, 0);   // fourth good: wrap
        send(1, 0, 0, 0, 0);   // R5 zero word count
        send(1, 0, 4, 0, 0);
        send(0, 1, 0, 0, 0);   // illegal command
        send(1, 0, 1, 0, 0);
        send(1, 0, 2, 0, 0);   // wrap, interrupt disabled
        for (int i = 0; i < 5; i++) send(i % 2 == 0, 0, 2, 1, i == 3);

        // R7 code 12 clamps to 512 messages
        setup(16'h0300, 16'h00C2, 16'hA000, 16'h8000);
        for (int i = 0; i < 1040; i++)
            send(i % 3 != 0, (i % 97) == 50, 1, 1, 0);

        // R2 inactive: ping-pong bit set, then circular bit clear
        setup(16'h0400, 16'h0006, 16'hC000, 16'hD000);
        send(1, 0, 2, 1, 0);
        setup(16'h0500, 16'h0001, 16'hC000, 16'hD000);
        send(1, 0, 2, 1, 0);
        check(rd16(16'h0502) == 16'hC000, "R2 descriptor untouched", int'(rd16(16'h0502)), 32'hC000);
    endtask

    initial begin
        bit wd = 0;
        fork
            run_all();
            begin
                repeat (190000) @(posedge clk);
                wd = 1;
            end
        join_any
        if (wd) begin
            fails++;
            $display("FAIL watchdog expired");
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks + mon_checks, fails + mon_fails);
        $finish;
    end

endmodule